// File: doc/BRIEF.md
# Peripheral Quadrant Power-Down Controller

This block holds the clock-gating state for a set of on-chip peripherals. The peripheral address space is cut into 1 KB selects. Each select is cut into four 256-byte quadrants, and each quadrant owns one control bit. The control bits are packed into 32-bit words, eight selects per word. Software reaches each word through two aliases on a simple register bus. One alias powers quadrants down. The other powers them up. Both aliases read back the same state.

A parameterised allocation map gives each peripheral a base quadrant and a quadrant count. A peripheral that spans several quadrants is governed only by the bit of its lowest quadrant. Every other bit that no peripheral owns has no storage and reads as zero. This includes the upper bits of a span. The block drives one registered clock-enable per peripheral, and the clock gating cells outside the block consume it.

Top module: `qpd_ctrl`

## Requirements
- R1: After synchronous reset every implemented bit reads 1 (powered down), every unimplemented bit reads 0, and every clock-enable output is 0.
- R2: A write to the set alias changes each implemented bit where the write data is 1 to 1 on the next clock edge. Data bits that are 0 leave their bits unchanged.
- R3: A write to the clear alias changes each implemented bit where the write data is 1 to 0 on the next clock edge. Data bits that are 0 leave their bits unchanged.
- R4: For the same word, the set alias and the clear alias return identical read data, and that data is the current state.
- R5: Bit positions that no peripheral owns always read 0, whatever is written to them.
- R6: For a peripheral spanning two or more quadrants, only the bit of its base quadrant is implemented and controls it. Writes to the other bits of the span have no effect on its clock-enable and read as 0.
- R7: Each clock-enable output is the registered inverse of its peripheral's control bit. It changes on the clock edge after the edge that commits the write.
- R8: Quadrant q of select s is bit (4*s+q) mod 32 of word (4*s+q)/32. Word r has its set alias at bus word address 2r and its clear alias at 2r+1. Addresses past the last word ignore writes and read 0.
- R9: The allocation map must place two-quadrant peripherals at quadrant 0 or 2 of a select, and larger spans on a select boundary. An illegal map stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W (3) | Word address: alias in bit 0, word index above it |
| bus_wdata | input | 32 | Write data, one bit per quadrant |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| periph_clk_en | output | NUM_PERIPH (8) | Registered clock-enable, one per peripheral |

## Verification
The bench targets the span rules first. It writes both aliases with every bit set, and it writes the upper bits of two-quadrant and eight-quadrant spans on their own. A design that stored those bits, or that let them reach a clock-enable, would show nonzero read-back or a wrong enable. Writes of all zeros to both aliases expose a design that loads the data instead of OR-ing or masking with it. Writes to addresses past the last word expose aliasing of the word index. A reference model compares the clock-enables on every cycle, so an enable that is combinational or one cycle too late shows up at once. A pseudo-random run mixes set and clear traffic across both words.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

    localparam int WORD_W   = 32;
    localparam int QUAD_PER_SEL = 4;

    typedef logic [7:0] qidx_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2
    } qop_e;

    // Placement rule: two-quadrant spans start on an even quadrant (0 or 2),
    // larger spans start on a select boundary.
    function automatic bit span_ok(input int base, input int span);
        if (span == 1)
            return 1'b1;
        else if (span == 2)
            return (base % 2) == 0;
        else if (span == 4 || span == 8)
            return (base % QUAD_PER_SEL) == 0;
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/qpd_bank.sv
module qpd_bank
    import qpd_pkg::*;
#(
    parameter logic [WORD_W-1:0] IMPL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  qop_e              op,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);

    logic [WORD_W-1:0] hit;
    assign hit = wdata & IMPL;

    always_ff @(posedge clk) begin
        if (rst)
            q <= IMPL;
        else if (op == OP_SET)
            q <= q | hit;
        else if (op == OP_CLR)
            q <= q & ~hit;
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        $past(rst) && !rst |-> q == IMPL);

    // R2
    set_effect_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_SET |=> (q & $past(hit)) == $past(hit));

    // R3
    clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_CLR |=> (q & $past(hit)) == '0);

    // R2
    zero_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op != OP_NONE |=> (q & ~$past(hit)) == ($past(q) & ~$past(hit)) ||
                          $past(op) == OP_SET);

    // R5
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (q & ~IMPL) == '0);

endmodule

// File: rtl/qpd_clken.sv
module qpd_clken
    import qpd_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int STATE_W    = 64,
    parameter qidx_t [NUM_PERIPH-1:0] BASE = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [STATE_W-1:0]    state,
    output logic [NUM_PERIPH-1:0] clk_en
);

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_en
        localparam int CTRL = int'(BASE[p]);

        always_ff @(posedge clk) begin
            if (rst)
                clk_en[p] <= 1'b0;
            else
                clk_en[p] <= ~state[CTRL];
        end

        // R7
        en_follows_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> clk_en[p] == ~$past(state[CTRL]));
    end

endmodule

// File: rtl/qpd_ctrl.sv
module qpd_ctrl
    import qpd_pkg::*;
#(
    parameter int NUM_SEL    = 16,
    parameter int NUM_PERIPH = 8,
    parameter qidx_t [NUM_PERIPH-1:0] PERIPH_BASE =
        {8'd36, 8'd33, 8'd16, 8'd10, 8'd8, 8'd2, 8'd1, 8'd0},
    parameter qidx_t [NUM_PERIPH-1:0] PERIPH_SPAN =
        {8'd1,  8'd1,  8'd8,  8'd2,  8'd2, 8'd2, 8'd1, 8'd1},
    localparam int TOTAL_Q = NUM_SEL * QUAD_PER_SEL,
    localparam int NUM_REG = (TOTAL_Q + WORD_W - 1) / WORD_W,
    localparam int ADDR_W  = $clog2(NUM_REG * 2) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [NUM_PERIPH-1:0] periph_clk_en
);

    localparam int STATE_W = NUM_REG * WORD_W;

    function automatic logic [STATE_W-1:0] build_impl();
        logic [STATE_W-1:0] m;
        m = '0;
        for (int p = 0; p < NUM_PERIPH; p++)
            m[int'(PERIPH_BASE[p])] = 1'b1;
        return m;
    endfunction

    localparam logic [STATE_W-1:0] IMPL = build_impl();

    // R9: map legality checked at elaboration
    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_map
        if (!span_ok(int'(PERIPH_BASE[p]), int'(PERIPH_SPAN[p])) ||
            int'(PERIPH_BASE[p]) + int'(PERIPH_SPAN[p]) > TOTAL_Q) begin : g_bad
            $error("illegal quadrant placement for peripheral %0d", p);
        end
    end

    logic [ADDR_W-2:0] reg_idx;
    logic              alias_clr;
    logic              in_range;

    assign reg_idx   = bus_addr[ADDR_W-1:1];
    assign alias_clr = bus_addr[0];
    assign in_range  = int'(reg_idx) < NUM_REG;

    logic [NUM_REG-1:0][WORD_W-1:0] bank_q;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_bank
        qop_e op;
        always_comb begin
            op = OP_NONE;
            if (bus_en && bus_we && in_range && int'(reg_idx) == r)
                op = alias_clr ? OP_CLR : OP_SET;
        end

        qpd_bank #(
            .IMPL (IMPL[r*WORD_W +: WORD_W])
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .op    (op),
            .wdata (bus_wdata),
            .q     (bank_q[r])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int r = 0; r < NUM_REG; r++)
            if (in_range && int'(reg_idx) == r)
                bus_rdata = bank_q[r];
    end

    qpd_clken #(
        .NUM_PERIPH (NUM_PERIPH),
        .STATE_W    (STATE_W),
        .BASE       (PERIPH_BASE)
    ) u_clken (
        .clk    (clk),
        .rst    (rst),
        .state  (bank_q),
        .clk_en (periph_clk_en)
    );

    // R8
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !in_range |-> bus_rdata == '0);

endmodule

// File: tb/tb_qpd_ctrl.sv
module tb_qpd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NQ = 64;
    localparam int BASE [NP] = '{0, 1, 2, 8, 10, 16, 33, 36};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] periph_clk_en;

    int compared = 0;
    int mismatched = 0;

    bit          mdl [NQ];
    bit          impl [NQ];
    logic [NP-1:0] exp_en;
    logic [31:0] lfsr = 32'hACE1_2357;

    always #(CLK_PERIOD/2) clk = ~clk;

    qpd_ctrl dut (
        .clk           (clk),
        .rst           (rst),
        .bus_en        (bus_en),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .periph_clk_en (periph_clk_en)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [31:0] v;
        int w;
        v = '0;
        w = int'(a) / 2;
        if (w < 2)
            for (int b = 0; b < 32; b++)
                v[b] = impl[w*32+b] & mdl[w*32+b];
        return v;
    endfunction

    task automatic step(input logic en, input logic we, input logic [2:0] a,
                        input logic [31:0] d, input string tag);
        logic [NP-1:0] nxt;
        logic [31:0]   e;
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        e = exp_read(a);
        compared++;
        if (bus_rdata !== e) begin
            mismatched++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, a, bus_rdata, e);
        end
        compared++;
        if (periph_clk_en !== exp_en) begin
            mismatched++;
            $display("FAIL R7 clk_en actual=%b expected=%b (%s)", periph_clk_en, exp_en, tag);
        end
        @(posedge clk);
        for (int p = 0; p < NP; p++) nxt[p] = ~mdl[BASE[p]];
        if (en && we && int'(a) < 4)
            for (int b = 0; b < 32; b++)
                if (d[b] && impl[(int'(a)/2)*32+b])
                    mdl[(int'(a)/2)*32+b] = ~a[0];
        exp_en = nxt;
        @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 8; a++) step(1'b1, 1'b0, 3'(a), 32'hFFFF_FFFF, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int q = 0; q < NQ; q++) impl[q] = 1'b0;
        for (int p = 0; p < NP; p++) impl[BASE[p]] = 1'b1;
        for (int q = 0; q < NQ; q++) mdl[q] = impl[q];
        exp_en = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset image, expected 0x00010507 / 0x00000012 on both aliases
        read_all("R1");
        // R4: both aliases of each word agree (compared against one model)
        read_all("R4");

        // R3: clear with zeros does nothing, then clear everything
        step(1'b1, 1'b1, 3'd1, 32'h0, "R3");
        read_all("R3");
        step(1'b1, 1'b1, 3'd1, 32'hFFFF_FFFF, "R3");
        step(1'b1, 1'b1, 3'd3, 32'hFFFF_FFFF, "R3");
        read_all("R5");

        // R2: set with zeros does nothing, then set single base bit
        step(1'b1, 1'b1, 3'd0, 32'h0, "R2");
        step(1'b1, 1'b1, 3'd0, 32'h0000_0100, "R2");
        read_all("R2");

        // R6: upper bits of spans (bit 9, bit 11, bits 23:17, bit 3)
        step(1'b1, 1'b1, 3'd0, 32'h00FE_0A08, "R6");
        read_all("R6");
        step(1'b1, 1'b1, 3'd1, 32'h0000_0100, "R6");
        step(1'b1, 1'b1, 3'd0, 32'h0001_0000, "R6");
        read_all("R6");

        // R5: unowned positions in word 1
        step(1'b1, 1'b1, 3'd2, 32'hFFFF_FFED, "R5");
        read_all("R5");

        // R8: out-of-range addresses ignore writes and read zero
        for (int a = 4; a < 8; a++) step(1'b1, 1'b1, 3'(a), 32'hFFFF_FFFF, "R8");
        read_all("R8");
        step(1'b1, 1'b1, 3'd2, 32'h0000_0002, "R8");
        read_all("R8");

        // R7: enables settle over idle cycles
        repeat (3) step(1'b0, 1'b0, 3'd0, 32'h0, "R7");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0], lfsr[1], lfsr[4:2], {lfsr[15:0], lfsr[31:16]},
                 lfsr[2] ? "R3" : "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule